// File: doc/BRIEF.md
# Trimmable Seconds Counter with Alarm

This block keeps wall-clock time as a running count of seconds. A slow tick, nominally 32768 pulses per second and presented as a one-cycle enable in the bus clock domain, feeds a prescaler. Each time the prescaler wraps, the seconds count advances. Software sets the time by loading a new count. It reads the current time from a live register, and it programs an alarm value. When the alarm matches the count, a sticky status flag is set and drives a maskable interrupt line.

A trim mechanism corrects a slow or fast oscillator. Software picks a period in seconds and a direction. Once per period, the seconds boundary then advances the count by two or by zero instead of by one. The resulting correction is 10^9/(period+1) parts per billion. An elaboration option makes the count, the load value and the alarm value live in Gray code. Software converts on either side, and the block increments in the binary domain and compares the stored forms directly.

All registers are 32 bits wide at word-aligned byte offsets. Writes take effect on the clock edge. Reads are combinational from the offset.

Top module: `sec_rtc`

## Requirements
- R1: After reset every readable register returns 0, `irq_o` is low and `clk_src_sel_o` is low.
- R2: The control register at 0x00 keeps alarm enable in bit 0, clock source select in bit 8 (also driven on `clk_src_sel_o`) and run enable in bit 12, and it reads back those bits in place.
- R3: While run is 1, the live count at 0x34 advances by one once every TICKS_PER_SEC pulses of `tick_i`, and it never changes in a cycle without a tick.
- R4: While run is 0, both the count and the prescaler hold, and tick pulses are ignored.
- R5: A write to 0x04 leaves the live count unchanged until the next tick pulse seen while running. That pulse copies the written value into the count and restarts the prescaler at zero. Reading 0x04 returns the written value.
- R6: The trim register at 0x18 holds the period in bits 18:0, the mode in bits 20:19 and valid in bit 23. A write restarts the period. With valid set, every (period+1)-th seconds boundary adds 2 when the mode is 3 and adds 0 when the mode is 2. Modes 0 and 1 step by 1.
- R7: With GRAY_STORE=1, the load, alarm and live values are Gray coded (g = b ^ (b >> 1)), and each seconds boundary advances the binary equivalent.
- R8: Bit 0 of the status register at 0x30 goes to 1 one cycle after a cycle in which alarm enable is 1 and the count equals the alarm register at 0x08. It then stays at 1.
- R9: Writing 1 to bit 0 of 0x24 clears the status, unless the alarm match holds in that same cycle. Writing 0 has no effect, and 0x24 reads 0.
- R10: `irq_o` is 1 exactly when the status is 1 and bit 0 of the mask register at 0x20 is 0.
- R11: Writes to the status (0x30) and live (0x34) offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle slow-time tick pulse |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| clk_src_sel_o | output | 1 | Clock source select from control bit 8 |
| irq_o | output | 1 | Alarm interrupt, status gated by mask |

## Verification
Two instances run side by side from the same stimulus, one storing binary and one storing Gray code. A mismatch that appears only in the Gray instance points at the conversion path, not at the counting. Directed sequences cover several distinct cases:
- loads made while stopped against loads made while running;
- the add and drop trims with short periods, set apart from the plain modes 0 and 1;
- clear while the alarm still matches, compared with clear after the alarm moved away.

Seeded random mixes of tick bursts, loads near the alarm, trim rewrites, run toggling and mask changes then exercise the interaction between the prescaler phase and the period counter, and between the prescaler phase and the sticky flag.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

   localparam int REG_W  = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h04;
   localparam logic [ADDR_W-1:0] OFS_ALARM = 8'h08;
   localparam logic [ADDR_W-1:0] OFS_TRIM  = 8'h18;
   localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h20;
   localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h30;
   localparam logic [ADDR_W-1:0] OFS_LIVE  = 8'h34;

   localparam int CTL_ALARM_BIT  = 0;
   localparam int CTL_SRC_BIT    = 8;
   localparam int CTL_RUN_BIT    = 12;
   localparam int TRIM_MODE_LO   = 19;
   localparam int TRIM_VALID_BIT = 23;
   localparam int TRIM_FIELD_MAX = 19;

   typedef enum logic [1:0] {
      TRIM_PLAIN0 = 2'd0,
      TRIM_PLAIN1 = 2'd1,
      TRIM_DROP   = 2'd2,
      TRIM_ADD    = 2'd3
   } trim_mode_e;

endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int MATCH_W = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [CNT_W-1:0]   live_cnt_i,
   input  logic               status_i,
   output logic [REG_W-1:0]   rdata_o,
   output logic               run_o,
   output logic               src_sel_o,
   output logic               alarm_en_o,
   output logic [CNT_W-1:0]   load_val_o,
   output logic               load_stb_o,
   output logic [CNT_W-1:0]   alarm_val_o,
   output logic               trim_valid_o,
   output trim_mode_e         trim_mode_o,
   output logic [MATCH_W-1:0] trim_period_o,
   output logic               trim_stb_o,
   output logic               mask_o,
   output logic               clr_stb_o
);

   logic hit_ctrl, hit_load, hit_alarm, hit_trim, hit_mask, hit_clr;

   assign hit_ctrl  = we_i && (addr_i == OFS_CTRL);
   assign hit_load  = we_i && (addr_i == OFS_LOAD);
   assign hit_alarm = we_i && (addr_i == OFS_ALARM);
   assign hit_trim  = we_i && (addr_i == OFS_TRIM);
   assign hit_mask  = we_i && (addr_i == OFS_MASK);
   assign hit_clr   = we_i && (addr_i == OFS_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o         <= 1'b0;
         src_sel_o     <= 1'b0;
         alarm_en_o    <= 1'b0;
         load_val_o    <= '0;
         alarm_val_o   <= '0;
         trim_valid_o  <= 1'b0;
         trim_mode_o   <= TRIM_PLAIN0;
         trim_period_o <= '0;
         mask_o        <= 1'b0;
      end else begin
         if (hit_ctrl) begin
            run_o      <= wdata_i[CTL_RUN_BIT];
            src_sel_o  <= wdata_i[CTL_SRC_BIT];
            alarm_en_o <= wdata_i[CTL_ALARM_BIT];
         end
         if (hit_load)  load_val_o  <= wdata_i[CNT_W-1:0];
         if (hit_alarm) alarm_val_o <= wdata_i[CNT_W-1:0];
         if (hit_trim) begin
            trim_valid_o  <= wdata_i[TRIM_VALID_BIT];
            trim_mode_o   <= trim_mode_e'(wdata_i[TRIM_MODE_LO +: 2]);
            trim_period_o <= wdata_i[MATCH_W-1:0];
         end
         if (hit_mask)  mask_o <= wdata_i[0];
      end
   end

   assign load_stb_o = hit_load;
   assign trim_stb_o = hit_trim;
   assign clr_stb_o  = hit_clr && wdata_i[0];

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         OFS_CTRL: begin
            rdata_o[CTL_RUN_BIT]   = run_o;
            rdata_o[CTL_SRC_BIT]   = src_sel_o;
            rdata_o[CTL_ALARM_BIT] = alarm_en_o;
         end
         OFS_LOAD:  rdata_o[CNT_W-1:0] = load_val_o;
         OFS_ALARM: rdata_o[CNT_W-1:0] = alarm_val_o;
         OFS_TRIM: begin
            rdata_o[MATCH_W-1:0]         = trim_period_o;
            rdata_o[TRIM_MODE_LO +: 2]   = trim_mode_o;
            rdata_o[TRIM_VALID_BIT]      = trim_valid_o;
         end
         OFS_MASK:  rdata_o[0] = mask_o;
         OFS_STAT:  rdata_o[0] = status_i;
         OFS_LIVE:  rdata_o[CNT_W-1:0] = live_cnt_i;
         default:   rdata_o = '0;
      endcase
   end

   // R2
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_ctrl |=> $stable(run_o) && $stable(alarm_en_o) && $stable(src_sel_o));

endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int MATCH_W       = 19,
   parameter int TICKS_PER_SEC = 32768,
   parameter bit GRAY_STORE    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               run_i,
   input  logic               load_stb_i,
   input  logic [CNT_W-1:0]   load_val_i,
   input  logic               trim_valid_i,
   input  trim_mode_e         trim_mode_i,
   input  logic [MATCH_W-1:0] trim_period_i,
   input  logic               trim_stb_i,
   output logic [CNT_W-1:0]   cnt_o
);

   localparam int PRE_W = $clog2(TICKS_PER_SEC);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);

   logic [PRE_W-1:0]   pre_q;
   logic [MATCH_W-1:0] adj_q;
   logic               pend_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_next;
   logic [1:0]         step;
   logic               advance, sec_wrap, trim_hit;

   assign advance  = run_i && tick_i;
   assign sec_wrap = advance && !pend_q && (pre_q == PRE_LAST);
   assign trim_hit = trim_valid_i && (adj_q == trim_period_i);

   always_comb begin
      step = 2'd1;
      if (trim_hit) begin
         unique case (trim_mode_i)
            TRIM_ADD:  step = 2'd2;
            TRIM_DROP: step = 2'd0;
            default:   step = 2'd1;
         endcase
      end
   end

   generate
      if (GRAY_STORE) begin : g_gray
         function automatic logic [CNT_W-1:0] to_bin(input logic [CNT_W-1:0] g);
            logic [CNT_W-1:0] b;
            b[CNT_W-1] = g[CNT_W-1];
            for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
            return b;
         endfunction
         logic [CNT_W-1:0] bin_sum;
         assign bin_sum  = to_bin(cnt_q) + CNT_W'(step);
         assign cnt_next = bin_sum ^ (bin_sum >> 1);
      end else begin : g_bin
         assign cnt_next = cnt_q + CNT_W'(step);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (load_stb_i) pend_q <= 1'b1;
         else if (advance && pend_q) pend_q <= 1'b0;
         if (advance) begin
            if (pend_q) begin
               cnt_q <= load_val_i;
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               cnt_q <= cnt_next;
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       adj_q <= '0;
      else if (trim_stb_i)              adj_q <= '0;
      else if (sec_wrap && trim_valid_i) adj_q <= trim_hit ? '0 : adj_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R4
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(cnt_o));

   // R3
   no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));

   // R6
   period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_valid_i && !trim_stb_i) |=> (adj_q <= trim_period_i));

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] alarm_val_i,
   input  logic             alarm_en_i,
   input  logic             clr_stb_i,
   input  logic             mask_i,
   output logic             status_o,
   output logic             irq_o
);

   logic st_q, match;

   assign match = alarm_en_i && (cnt_i == alarm_val_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         st_q <= 1'b0;
      else if (match)     st_q <= 1'b1;
      else if (clr_stb_i) st_q <= 1'b0;
   end

   assign status_o = st_q;
   assign irq_o    = st_q && !mask_i;

   // R8
   set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> st_q);

   // R8
   rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q) |-> $past(alarm_en_i));

   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb_i && !match) |=> !st_q);

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && !clr_stb_i) |=> st_q);

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
   import sec_rtc_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int MATCH_W       = 19,
   parameter int TICKS_PER_SEC = 32768,
   parameter bit GRAY_STORE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   output logic              clk_src_sel_o,
   output logic              irq_o
);

   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
         $error("sec_rtc: CNT_W out of range");
      end
      if (MATCH_W < 1 || MATCH_W > TRIM_FIELD_MAX) begin : g_bad_match
         $error("sec_rtc: MATCH_W out of range");
      end
      if (TICKS_PER_SEC < 2) begin : g_bad_tps
         $error("sec_rtc: TICKS_PER_SEC must be at least 2");
      end
   endgenerate

   logic               run, alarm_en, load_stb, trim_valid, trim_stb, mask, clr_stb, status;
   logic [CNT_W-1:0]   load_val, alarm_val, cnt;
   logic [MATCH_W-1:0] trim_period;
   trim_mode_e         trim_mode;

   sec_rtc_regs #(.CNT_W(CNT_W), .MATCH_W(MATCH_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .live_cnt_i(cnt), .status_i(status),
      .rdata_o(bus_rdata_o), .run_o(run), .src_sel_o(clk_src_sel_o),
      .alarm_en_o(alarm_en), .load_val_o(load_val), .load_stb_o(load_stb),
      .alarm_val_o(alarm_val), .trim_valid_o(trim_valid), .trim_mode_o(trim_mode),
      .trim_period_o(trim_period), .trim_stb_o(trim_stb), .mask_o(mask),
      .clr_stb_o(clr_stb)
   );

   sec_rtc_core #(.CNT_W(CNT_W), .MATCH_W(MATCH_W), .TICKS_PER_SEC(TICKS_PER_SEC),
                  .GRAY_STORE(GRAY_STORE)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
      .load_stb_i(load_stb), .load_val_i(load_val), .trim_valid_i(trim_valid),
      .trim_mode_i(trim_mode), .trim_period_i(trim_period), .trim_stb_i(trim_stb),
      .cnt_o(cnt)
   );

   sec_rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .alarm_val_i(alarm_val),
      .alarm_en_i(alarm_en), .clr_stb_i(clr_stb), .mask_i(mask),
      .status_o(status), .irq_o(irq_o)
   );

endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
   localparam int TPS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0, wdata_g = '0;
   logic [31:0] rdata, rdata_g;
   logic        src, src_g, irq, irq_g;

   int nvec = 0, nfail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sec_rtc #(.TICKS_PER_SEC(TPS), .GRAY_STORE(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .clk_src_sel_o(src), .irq_o(irq));

   sec_rtc #(.TICKS_PER_SEC(TPS), .GRAY_STORE(1'b1)) dut_g (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata_g), .bus_rdata_o(rdata_g), .clk_src_sel_o(src_g), .irq_o(irq_g));

   // bench model state
   bit          m_run, m_alen, m_pend, m_tv, m_st, m_mask;
   logic [31:0] m_cnt, m_ld, m_alm;
   logic [1:0]  m_mode;
   logic [18:0] m_per, m_adj;
   int          m_pre;

   function automatic logic [31:0] gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic eval_alarm();
      if (m_alen && m_cnt == m_alm) m_st = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      wdata_g = (a == 8'h04 || a == 8'h08) ? gray(d) : d;
      @(negedge clk);
      we = 1'b0;
      case (a)
         8'h00: begin m_run = d[12]; m_alen = d[0]; end
         8'h04: begin m_ld = d; m_pend = 1'b1; end
         8'h08: m_alm = d;
         8'h18: begin m_tv = d[23]; m_mode = d[20:19]; m_per = d[18:0]; m_adj = '0; end
         8'h20: m_mask = d[0];
         8'h24: if (d[0]) m_st = m_alen && (m_cnt == m_alm);
         default: ;
      endcase
      eval_alarm();
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dg);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata; dg = rdata_g;
   endtask

   task automatic tick_n(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         if (m_run) begin
            if (m_pend) begin
               m_cnt = m_ld; m_pre = 0; m_pend = 1'b0;
            end else if (m_pre == TPS - 1) begin
               m_pre = 0;
               if (m_tv && m_adj == m_per) begin
                  m_adj = '0;
                  m_cnt = m_cnt + ((m_mode == 2'd3) ? 32'd2 : (m_mode == 2'd2) ? 32'd0 : 32'd1);
               end else begin
                  m_cnt = m_cnt + 32'd1;
                  if (m_tv) m_adj = m_adj + 1'b1;
               end
            end else begin
               m_pre++;
            end
         end
         eval_alarm();
      end
   endtask

   task automatic check_state(input string req);
      logic [31:0] d, dg;
      rd(8'h34, d, dg);
      chk({req, " live"}, d, m_cnt);
      chk({req, " live gray R7"}, dg, gray(m_cnt));
      rd(8'h30, d, dg);
      chk({req, " status"}, d, {31'b0, m_st});
      chk({req, " status gray"}, dg, {31'b0, m_st});
      chk({req, " irq R10"}, {31'b0, irq}, {31'b0, m_st && !m_mask});
      chk({req, " irq gray R10"}, {31'b0, irq_g}, {31'b0, m_st && !m_mask});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, dg;
      logic [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h20, 8'h24, 8'h30, 8'h34};
      m_run = 0; m_alen = 0; m_pend = 0; m_tv = 0; m_st = 0; m_mask = 0;
      m_cnt = 0; m_ld = 0; m_alm = 0; m_mode = 0; m_per = 0; m_adj = 0; m_pre = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      foreach (offs[i]) begin
         rd(offs[i], d, dg);
         chk("R1 reg", d, 32'h0);
         chk("R1 reg gray", dg, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 src", {31'b0, src}, 32'h0);

      // R2 control bit positions
      wr(8'h00, 32'h0000_0100);
      rd(8'h00, d, dg);
      chk("R2 ctrl src", d, 32'h0000_0100);
      chk("R2 src pin", {31'b0, src}, 32'h1);
      wr(8'h00, 32'hFFFF_EEFF);
      rd(8'h00, d, dg);
      chk("R2 ctrl others ignored", d, 32'h0000_0001);
      wr(8'h00, 32'h0);

      // R4 stopped: ticks ignored, load stays pending
      wr(8'h04, 32'd100);
      tick_n(10);
      check_state("R4");
      rd(8'h04, d, dg);
      chk("R5 load readback", d, 32'd100);
      chk("R5 load readback gray", dg, gray(32'd100));

      // R5 load applies on next running tick
      wr(8'h00, 32'h0000_1000);
      check_state("R5 before tick");
      tick_n(1);
      chk("R5 loaded", m_cnt, 32'd100);
      check_state("R5 after tick");
      tick_n(TPS - 1);
      check_state("R3 partial second");
      tick_n(1);
      check_state("R3 one second");
      tick_n(TPS * 5);
      check_state("R3 five seconds");

      // R6 add and drop trims
      wr(8'h18, 32'h0098_0002);   // valid, mode 3, period 2
      rd(8'h18, d, dg);
      chk("R6 trim readback", d, 32'h0098_0002);
      tick_n(TPS * 3);
      check_state("R6 add");
      wr(8'h18, 32'h0090_0001);   // valid, mode 2, period 1
      tick_n(TPS * 4);
      check_state("R6 drop");
      wr(8'h18, 32'h0088_0000);   // valid, mode 1, period 0
      tick_n(TPS * 3);
      check_state("R6 plain mode");
      wr(8'h18, 32'h0);

      // R8 R9 R10 alarm
      wr(8'h08, m_cnt + 32'd2);
      wr(8'h00, 32'h0000_1001);
      tick_n(TPS * 2);
      check_state("R8 alarm hit");
      wr(8'h20, 32'h1);
      check_state("R10 masked");
      wr(8'h24, 32'h1);
      check_state("R9 clear while matching");
      wr(8'h24, 32'h0);
      check_state("R9 clear zero");
      rd(8'h24, d, dg);
      chk("R9 clr reads zero", d, 32'h0);
      wr(8'h08, m_cnt + 32'd50);
      wr(8'h24, 32'h1);
      check_state("R9 cleared");
      wr(8'h20, 32'h0);

      // R11 read-only offsets
      wr(8'h30, 32'h1);
      wr(8'h34, 32'h1234_5678);
      check_state("R11 writes ignored");

      // seeded random mix
      void'($urandom(32'd12345));
      for (int it = 0; it < 300; it++) begin
         int op;
         op = $urandom % 10;
         case (op)
            0, 1, 2, 3: tick_n(1 + $urandom % 12);
            4: wr(8'h04, (($urandom % 4) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : m_alm - ($urandom % 4));
            5: wr(8'h08, m_cnt + ($urandom % 4));
            6: wr(8'h00, {19'b0, (($urandom % 4) != 0), 3'b0, 1'b0, 7'b0, 1'($urandom % 2)});
            7: wr(8'h18, {8'b0, 1'($urandom % 2), 2'b0, 2'($urandom % 4), 19'($urandom % 7)});
            8: wr(8'h20, {31'b0, 1'($urandom % 2)});
            default: wr(8'h24, 32'h1);
         endcase
         check_state("R3 R6 R8 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule